// File: doc/BRIEF.md
# Event Combiner and Priority Mux

This block sits between a large set of peripheral event lines and the twelve external priority inputs of a core interrupt prioritizer. It takes 128 event lines. Event lines 4 to 127 each set a sticky flag on a rising edge. Software clears a flag by writing a one to its bit.

The flags fall into four groups of 32, and event `e` belongs to group `e/32`, bit `e%32`. Each group has a mask register. A group's combined output is the OR of its flagged, unmasked bits. The four combined outputs are exposed as event numbers 0 to 3.

Twelve selectors, one for each core level 4 to 15, decide what drives each level output. A selector can name one of the combined outputs (0 to 3) or route one flagged event (4 to 127) straight to the level. A directly routed event ignores its group mask. A selector can also be disabled, so that its level carries nothing. All state is reached over a simple synchronous register bus.

Top module: `evt_route_top`

## Requirements
- R1: After reset all flags and masks are zero. Selector entries 8 to 11 (levels 12 to 15) hold enable=1 with combined outputs 0 to 3, entries 0 to 7 are disabled, and every level output is low.
- R2: A flag is set only by a 0-to-1 change of its event line. An event held high sets the flag once, and a flag cleared while the line stays high remains clear.
- R3: Writing a flag register clears each flag whose write bit is 1 and leaves the bits written 0 unchanged. If a rising edge and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: Flags for events 0 to 3 (group 0, bits 0 to 3) always read zero and never contribute to any output.
- R5: Combined output g is high while any flag in group g has its mask bit at 0. A mask bit at 1 blocks that flag from the group output but leaves the flag readable.
- R6: An enabled selector holding a value 0 to 3 drives its level with the matching combined output.
- R7: An enabled selector holding a value 4 to 127 drives its level with that event's flag, regardless of the event's mask bit.
- R8: A selector whose enable bit is 0 drives its level low, whatever its event field holds.
- R9: Register map: addresses 0 to 3 are the flag registers of groups 0 to 3 (read; write-one-to-clear). Addresses 4 to 7 are the group masks. Addresses 8 to 19 are selector entries 0 to 11, where bit 7 is the enable and bits 6:0 are the event number. Other addresses read zero and ignore writes.
- R10: A level output reflects the new flag in the clock cycle after the edge that samples the event rising. `lvl_out[i]` is core level i+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 128 | Event lines, index is event number |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lvl_out | output | 12 | Level outputs, bit i drives core level i+4 |

## Verification
The hardest situation to reach from the ports is a rising edge that arrives in the same cycle as a software clear of the same flag. The bench raises the event line and issues the clearing write in a single tick, then reads the flag back. A second case that is hard to produce is an event held high across a clear. The bench keeps the line asserted for several cycles, clears the flag, and confirms that the flag stays clear. The mask bypass of direct routing is observed by masking an event that is both routed directly and part of a combined level, then checking that only the directly routed level rises.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
    localparam int NUM_GRP   = 4;
    localparam int GRP_W     = 32;
    localparam int NUM_EVT   = NUM_GRP * GRP_W;
    localparam int NUM_LVL   = 12;
    localparam int EVT_W     = $clog2(NUM_EVT);
    localparam int ADDR_W    = 5;
    localparam int MASK_BASE = NUM_GRP;
    localparam int SEL_BASE  = 2 * NUM_GRP;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 32,
    localparam int N      = NUM_GRP * GRP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    // group 0 bits 0..3 name combined outputs, never real sources
    localparam logic [N-1:0] LIVE = {{(N-NUM_GRP){1'b1}}, {NUM_GRP{1'b0}}};

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flag;
    } st_t;

    st_t q, d;
    logic [N-1:0] rise;

    always_comb begin
        d      = q;
        rise   = evt_i & ~q.prev & LIVE;
        d.prev = evt_i;
        d.flag = ((q.flag & ~clr_i) | rise) & LIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign flag_o = q.flag;

    // R2
    flag_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(evt_i & ~q.prev)) == '0));
    // R3
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_o & $past(clr_i & ~(evt_i & ~q.prev))) == '0));
    // R4
    tied_bits_low_chk: assert property (@(posedge clk) disable iff (rst)
        flag_o[NUM_GRP-1:0] == '0);
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner #(
    parameter int NUM_GRP   = 4,
    parameter int GRP_W     = 32,
    parameter int ADDR_W    = 5,
    parameter int MASK_BASE = 4,
    localparam int N        = NUM_GRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GRP_W-1:0]  wdata_i,
    input  logic [N-1:0]      flag_i,
    output logic [N-1:0]      mask_o,
    output logic [NUM_GRP-1:0] comb_o
);
    typedef struct packed {
        logic [NUM_GRP-1:0][GRP_W-1:0] mask;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (we_i && int'(addr_i) == MASK_BASE + g) d.mask[g] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign mask_o = q.mask;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign comb_o[g] = |(flag_i[g*GRP_W +: GRP_W] & ~q.mask[g]);

        // R9
        mask_write_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && int'(addr_i) == MASK_BASE + g) |=> (mask_o[g*GRP_W +: GRP_W] == $past(wdata_i)));
        // R5
        masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            ((flag_i[g*GRP_W +: GRP_W] & ~mask_o[g*GRP_W +: GRP_W]) == '0) |-> !comb_o[g]);
    end
endmodule

// File: rtl/evt_level_sel.sv
module evt_level_sel #(
    parameter int NUM_LVL  = 12,
    parameter int NUM_GRP  = 4,
    parameter int EVT_W    = 7,
    parameter int ADDR_W   = 5,
    parameter int SEL_BASE = 8,
    localparam int N       = 1 << EVT_W,
    localparam int SEL_W   = EVT_W + 1,
    localparam int GSEL_W  = $clog2(NUM_GRP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [SEL_W-1:0]         wdata_i,
    input  logic [NUM_GRP-1:0]       comb_i,
    input  logic [N-1:0]             flag_i,
    output logic [NUM_LVL*SEL_W-1:0] sel_o,
    output logic [NUM_LVL-1:0]       lvl_o
);
    typedef logic [NUM_LVL-1:0][SEL_W-1:0] sel_arr_t;

    typedef struct packed {
        sel_arr_t sel;
    } st_t;

    function automatic sel_arr_t reset_sel();
        sel_arr_t r = '0;
        for (int i = NUM_LVL - NUM_GRP; i < NUM_LVL; i++) begin
            r[i] = {1'b1, EVT_W'(i - (NUM_LVL - NUM_GRP))};
        end
        return r;
    endfunction

    st_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (we_i && int'(addr_i) == SEL_BASE + i) d.sel[i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q.sel <= reset_sel();
        else     q <= d;
    end

    assign sel_o = q.sel;

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        logic             en;
        logic [EVT_W-1:0] num;
        assign en  = q.sel[i][EVT_W];
        assign num = q.sel[i][EVT_W-1:0];

        always_comb begin
            if (!en)                  lvl_o[i] = 1'b0;
            else if (num < NUM_GRP)   lvl_o[i] = comb_i[num[GSEL_W-1:0]];
            else                      lvl_o[i] = flag_i[num];
        end

        // R8
        disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
            !sel_o[i*SEL_W + EVT_W] |-> !lvl_o[i]);
        // R9
        sel_write_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && int'(addr_i) == SEL_BASE + i) |=> (sel_o[i*SEL_W +: SEL_W] == $past(wdata_i)));
    end
endmodule

// File: rtl/evt_route_top.sv
module evt_route_top
    import evt_route_pkg::*;
#(
    parameter int P_NUM_GRP = NUM_GRP,
    parameter int P_GRP_W   = GRP_W,
    parameter int P_NUM_LVL = NUM_LVL,
    localparam int N        = P_NUM_GRP * P_GRP_W,
    localparam int P_EVT_W  = $clog2(N),
    localparam int SEL_W    = P_EVT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         evt_in,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [P_GRP_W-1:0]   bus_wdata,
    output logic [P_GRP_W-1:0]   bus_rdata,
    output logic [P_NUM_LVL-1:0] lvl_out
);
    logic [N-1:0]                 clr;
    logic [N-1:0]                 flag;
    logic [N-1:0]                 mask;
    logic [P_NUM_GRP-1:0]         comb;
    logic [P_NUM_LVL*SEL_W-1:0]   sel;

    always_comb begin
        clr = '0;
        for (int g = 0; g < P_NUM_GRP; g++) begin
            if (bus_we && int'(bus_addr) == g) clr[g*P_GRP_W +: P_GRP_W] = bus_wdata;
        end
    end

    evt_flag_bank #(.NUM_GRP(P_NUM_GRP), .GRP_W(P_GRP_W)) u_flags (
        .clk(clk), .rst(rst), .evt_i(evt_in), .clr_i(clr), .flag_o(flag)
    );

    evt_combiner #(.NUM_GRP(P_NUM_GRP), .GRP_W(P_GRP_W), .ADDR_W(ADDR_W),
                   .MASK_BASE(P_NUM_GRP)) u_comb (
        .clk(clk), .rst(rst), .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .flag_i(flag), .mask_o(mask), .comb_o(comb)
    );

    evt_level_sel #(.NUM_LVL(P_NUM_LVL), .NUM_GRP(P_NUM_GRP), .EVT_W(P_EVT_W),
                    .ADDR_W(ADDR_W), .SEL_BASE(2 * P_NUM_GRP)) u_sel (
        .clk(clk), .rst(rst), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata[SEL_W-1:0]), .comb_i(comb), .flag_i(flag),
        .sel_o(sel), .lvl_o(lvl_out)
    );

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < P_NUM_GRP; g++) begin
            if (int'(bus_addr) == g)             bus_rdata = flag[g*P_GRP_W +: P_GRP_W];
            if (int'(bus_addr) == P_NUM_GRP + g) bus_rdata = mask[g*P_GRP_W +: P_GRP_W];
        end
        for (int i = 0; i < P_NUM_LVL; i++) begin
            if (int'(bus_addr) == 2 * P_NUM_GRP + i)
                bus_rdata = P_GRP_W'(sel[i*SEL_W +: SEL_W]);
        end
    end

    // R7
    direct_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (sel[P_EVT_W] && sel[P_EVT_W-1:0] >= P_EVT_W'(P_NUM_GRP)) |-> (lvl_out[0] == flag[sel[P_EVT_W-1:0]]));
endmodule

// File: tb/evt_route_top_tb.sv
module evt_route_top_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] evt_in;
    logic         bus_we;
    logic [4:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [11:0]  lvl_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_route_top u_dut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_out(lvl_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = v;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = 5'(a);
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input int e);
        evt_in[e] = 1'b1;
        tick();
        evt_in[e] = 1'b0;
        tick();
    endtask

    task automatic clear_all();
        for (int g = 0; g < 4; g++) wr(g, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a, v); chk("R1 flag/mask reset", v, 32'h0);
        end
        for (int i = 0; i < 12; i++) begin
            rd(8 + i, v);
            chk("R1 selector reset", v, (i >= 8) ? (32'h80 | 32'(i - 8)) : 32'h0);
        end
        chk("R1 levels low", 32'(lvl_out), 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        evt_in[40] = 1'b1;
        tick();
        chk("R10 level one cycle after edge", 32'(lvl_out), 32'h200);
        evt_in[40] = 1'b0;
        tick();
        rd(1, v); chk("R2 flag set by edge", v, 32'h100);
        wr(1, 32'h100);
        rd(1, v); chk("R3 write one clears", v, 32'h0);
        chk("R5 group output drops", 32'(lvl_out), 32'h0);
        evt_in[50] = 1'b1;
        tick(); tick(); tick();
        wr(1, 32'h4_0000);
        tick();
        rd(1, v); chk("R2 held line no re-set", v, 32'h0);
        evt_in[50] = 1'b0;
        tick();
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        pulse(71);
        evt_in[70] = 1'b1;
        wr(2, 32'h40);
        evt_in[70] = 1'b0;
        tick();
        rd(2, v); chk("R3 set wins, zero bits kept", v, 32'hC0);
        clear_all();
    endtask

    task automatic t_tied();
        logic [31:0] v;
        for (int e = 0; e < 4; e++) pulse(e);
        rd(0, v); chk("R4 low bits read zero", v, 32'h0);
        chk("R4 no output", 32'(lvl_out), 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(7, 32'h1);
        pulse(96);
        chk("R5 masked blocks group", 32'(lvl_out), 32'h0);
        rd(3, v); chk("R5 masked flag readable", v, 32'h1);
        wr(7, 32'h0);
        chk("R5 unmasked drives group", 32'(lvl_out), 32'h800);
        clear_all();
    endtask

    task automatic t_route_comb();
        pulse(65);
        chk("R6 selector to combined 2", 32'(lvl_out), 32'h401);
        clear_all();
    endtask

    task automatic t_route_direct();
        wr(11, 32'hE4);
        wr(7, 32'h10);
        pulse(100);
        chk("R7 direct ignores mask", 32'(lvl_out), 32'h008);
        clear_all();
        chk("R7 direct follows clear", 32'(lvl_out), 32'h0);
    endtask

    task automatic t_disabled();
        wr(13, 32'h05);
        pulse(5);
        chk("R8 disabled level low", 32'(lvl_out), 32'h100);
        clear_all();
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(25, 32'hDEAD_BEEF);
        rd(25, v); chk("R9 unmapped reads zero", v, 32'h0);
        rd(4, v);  chk("R9 mask0 untouched", v, 32'h0);
        rd(13, v); chk("R9 selector readback", v, 32'h05);
        rd(11, v); chk("R9 selector 3 readback", v, 32'hE4);
        rd(7, v);  chk("R9 mask3 readback", v, 32'h10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_edge();
        t_same_cycle();
        t_tied();
        t_mask();
        wr(8, 32'h82);
        t_route_comb();
        t_route_direct();
        t_disabled();
        t_map();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule